// File: doc/BRIEF.md
# Twenty-Five Tap Signed Dot Product Engine

This block forms the dot product of a 5x5 window of signed samples with a 5x5 set of signed weights, then adds a signed bias. All twenty-five lanes arrive on every cycle as flattened buses. Every lane has its own multiplier, and all twenty-five products are registered at once. A registered binary adder tree then reduces them. The tree is laid out as if it had thirty-two inputs. Lanes 0 to 23 are summed in adjacent pairs into twelve partial sums, which are padded with zeros to sixteen. The sixteen are then halved to eight, four and two. Lane 24 does not enter the tree. It travels through a matched delay and joins the last two partial sums in a single three-operand stage. One more stage adds the bias, which is carried through the pipeline alongside the window it came with.

The engine accepts a new window on every cycle that `in_valid` is high. Each result leaves after a fixed latency, flagged by `out_valid`. Every width grows with the arithmetic, so no intermediate value or result can wrap. It is intended as the arithmetic core of one output pixel of a convolution layer. Summing across input channels and applying an activation belong to the logic around it.

Top module: `window_dot25`

## Requirements
- R1: Lane i (0 to 24) of the window is `win_flat[i*DATA_W +: DATA_W]` and lane i of the weights is `kern_flat[i*COEF_W +: COEF_W]`. Both are two's complement, and each window lane is multiplied only by the weight lane with the same index.
- R2: The result equals the bias plus the sum of all 25 signed products, computed exactly. It is sign-extended into `RES_W = max(DATA_W+COEF_W+5, BIAS_W)+1` bits and never wraps, even when every operand is at an extreme.
- R3: A window accepted at rising edge e (with `in_valid` high) produces `out_valid` high with its result immediately after rising edge e+6. That is seven register stages, counting the edge that accepts the window.
- R4: Windows presented on consecutive cycles each produce their own result on consecutive cycles, in arrival order, with no bubbles.
- R5: While `rst_n` is low, `out_valid` is 0 and `out_sum` is 0. After release the pipeline starts empty.
- R6: A cycle with `in_valid` low produces no result, whatever is on the data inputs. While `out_valid` is low, `out_sum` keeps the last result it showed (0 if there has been none).
- R7: All-minimum operands (every product positive and maximal), all-maximum operands, and minimum times maximum (every product maximally negative) all give exact results, with the bias at either extreme.
- R8: Lane 24, which bypasses the tree, contributes to the same result as lanes 0 to 23 of the same window. It never contributes to a neighbouring window's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when a window is presented |
| win_flat | input | 25*DATA_W | Window samples, lane i at bits i*DATA_W upward, signed |
| kern_flat | input | 25*COEF_W | Weights, lane i at bits i*COEF_W upward, signed |
| bias | input | BIAS_W | Signed bias added to this window's sum |
| out_valid | output | 1 | High for one cycle per result |
| out_sum | output | RES_W | Signed dot product plus bias |

## Verification
Two paths meet in the same cycle: the last tree stage, which combines the two surviving partial sums, and the bypass path that carries lane 24. The bench provokes this meeting by sending windows back to back where only lane 24 is non-zero, interleaved with windows where lane 24 is zero and every other lane is at full scale. Any slip of one cycle in the bypass delay moves a product into a neighbouring result. The bias delay is exposed in the same way, because random biases change on every cycle. The bench judges every output cycle against a serial reference sum that travels through a queue as deep as the pipeline.

// File: rtl/dot25_pkg.sv
`timescale 1ns/1ps
package dot25_pkg;
  localparam int TAPS      = 25;
  localparam int TREE_TAPS = 24;
  localparam int PIPE_LAT  = 7;

  // full-precision signed product width
  function automatic int prod_w(input int dw, input int cw);
    return dw + cw;
  endfunction

  // width after a given number of pairwise additions
  function automatic int level_w(input int pw, input int lvl);
    return pw + lvl;
  endfunction

  // width of final tree+bypass sum (25 terms < 2**5)
  function automatic int tree_sum_w(input int dw, input int cw);
    return prod_w(dw, cw) + 5;
  endfunction

  // result width, one bit above the wider bias/tree operand
  function automatic int res_w(input int dw, input int cw, input int bw);
    int t;
    t = tree_sum_w(dw, cw);
    return ((t > bw) ? t : bw) + 1;
  endfunction
endpackage

// File: rtl/lane_multiplier_array.sv
`timescale 1ns/1ps
module lane_multiplier_array
  import dot25_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int LANES  = 25
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_vld,
  input  logic signed [DATA_W-1:0]              win  [LANES],
  input  logic signed [COEF_W-1:0]              kern [LANES],
  output logic                                  out_vld,
  output logic signed [prod_w(DATA_W,COEF_W)-1:0] prod [LANES]
);
  localparam int PW = prod_w(DATA_W, COEF_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prod[g] <= '0;
      else if (in_vld) prod[g] <= PW'(win[g]) * PW'(kern[g]);
    end
  end
endmodule

// File: rtl/pair_adder_stage.sv
`timescale 1ns/1ps
module pair_adder_stage #(
  parameter int N_OUT = 2,
  parameter int IN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic signed [IN_W-1:0] din  [2*N_OUT],
  output logic                   out_vld,
  output logic signed [IN_W:0]   dout [N_OUT]
);
  localparam int OW = IN_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout[g] <= '0;
      else if (in_vld) dout[g] <= OW'(din[2*g]) + OW'(din[2*g+1]);
    end
  end
endmodule

// File: rtl/sample_delay.sv
`timescale 1ns/1ps
module sample_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);
  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_regs
    logic signed [W-1:0] stage [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else begin
        stage[0] <= d;
        for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
    end
    assign q = stage[DEPTH-1];
  end
endmodule

// File: rtl/window_dot25.sv
`timescale 1ns/1ps
module window_dot25
  import dot25_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int BIAS_W = 16
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            in_valid,
  input  logic [TAPS*DATA_W-1:0]                          win_flat,
  input  logic [TAPS*COEF_W-1:0]                          kern_flat,
  input  logic signed [BIAS_W-1:0]                        bias,
  output logic                                            out_valid,
  output logic signed [res_w(DATA_W,COEF_W,BIAS_W)-1:0]   out_sum
);
  localparam int PW    = prod_w(DATA_W, COEF_W);
  localparam int W1    = level_w(PW, 1);
  localparam int W2    = level_w(PW, 2);
  localparam int W3    = level_w(PW, 3);
  localparam int W4    = level_w(PW, 4);
  localparam int SUM_W = tree_sum_w(DATA_W, COEF_W);
  localparam int RES_W = res_w(DATA_W, COEF_W, BIAS_W);
  localparam int N1    = TREE_TAPS / 2;   // 12 real pair sums
  localparam int N1P   = 16;              // padded to a power of two
  localparam int LEFT_DLY = 4;            // product reg -> tail stage
  localparam int BIAS_DLY = PIPE_LAT - 1; // input -> output stage

  // lane unpacking
  logic signed [DATA_W-1:0] win_lane  [TAPS];
  logic signed [COEF_W-1:0] kern_lane [TAPS];
  for (genvar g = 0; g < TAPS; g++) begin : g_unpack
    assign win_lane[g]  = win_flat[g*DATA_W +: DATA_W];
    assign kern_lane[g] = kern_flat[g*COEF_W +: COEF_W];
  end

  // multiply stage
  logic                 prod_vld;
  logic signed [PW-1:0] prod_lane [TAPS];
  lane_multiplier_array #(.DATA_W(DATA_W), .COEF_W(COEF_W), .LANES(TAPS)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_vld(in_valid),
    .win(win_lane), .kern(kern_lane),
    .out_vld(prod_vld), .prod(prod_lane)
  );

  // tree feed: lanes 0..23 only
  logic signed [PW-1:0] tree_in [TREE_TAPS];
  for (genvar g = 0; g < TREE_TAPS; g++) begin : g_feed
    assign tree_in[g] = prod_lane[g];
  end
  logic signed [PW-1:0] prod_last;
  assign prod_last = prod_lane[TAPS-1];

  // level 1: 24 -> 12
  logic                 lvl1_vld;
  logic signed [W1-1:0] l1 [N1];
  pair_adder_stage #(.N_OUT(N1), .IN_W(PW)) u_lvl1 (
    .clk(clk), .rst_n(rst_n), .in_vld(prod_vld), .din(tree_in),
    .out_vld(lvl1_vld), .dout(l1)
  );

  // pad 12 -> 16 with zeros
  logic signed [W1-1:0] l1p [N1P];
  for (genvar g = 0; g < N1P; g++) begin : g_pad
    if (g < N1) begin : g_real
      assign l1p[g] = l1[g];
    end else begin : g_zero
      assign l1p[g] = '0;
    end
  end

  // levels 2..4: 16 -> 8 -> 4 -> 2
  logic                 lvl2_vld, lvl3_vld, lvl4_vld;
  logic signed [W2-1:0] l2 [8];
  logic signed [W3-1:0] l3 [4];
  logic signed [W4-1:0] l4 [2];
  pair_adder_stage #(.N_OUT(8), .IN_W(W1)) u_lvl2 (
    .clk(clk), .rst_n(rst_n), .in_vld(lvl1_vld), .din(l1p),
    .out_vld(lvl2_vld), .dout(l2)
  );
  pair_adder_stage #(.N_OUT(4), .IN_W(W2)) u_lvl3 (
    .clk(clk), .rst_n(rst_n), .in_vld(lvl2_vld), .din(l2),
    .out_vld(lvl3_vld), .dout(l3)
  );
  pair_adder_stage #(.N_OUT(2), .IN_W(W3)) u_lvl4 (
    .clk(clk), .rst_n(rst_n), .in_vld(lvl3_vld), .din(l3),
    .out_vld(lvl4_vld), .dout(l4)
  );

  // bypass lane and bias travel on their own delay lines
  logic signed [PW-1:0]     left_lane;
  logic signed [BIAS_W-1:0] bias_d;
  sample_delay #(.W(PW), .DEPTH(LEFT_DLY)) u_left (
    .clk(clk), .rst_n(rst_n), .d(prod_last), .q(left_lane)
  );
  sample_delay #(.W(BIAS_W), .DEPTH(BIAS_DLY)) u_bias (
    .clk(clk), .rst_n(rst_n), .d(bias), .q(bias_d)
  );

  // tail: last pair plus bypass lane
  logic                    tail_vld;
  logic signed [SUM_W-1:0] tree_sum;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_vld <= 1'b0;
      tree_sum <= '0;
    end else begin
      tail_vld <= lvl4_vld;
      if (lvl4_vld) tree_sum <= SUM_W'(l4[0]) + SUM_W'(l4[1]) + SUM_W'(left_lane);
    end
  end

  // bias stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= tail_vld;
      if (tail_vld) out_sum <= RES_W'(tree_sum) + RES_W'(bias_d);
    end
  end
endmodule

// File: rtl/window_dot25_chk.sv
`timescale 1ns/1ps
module window_dot25_chk
  import dot25_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int BIAS_W = 16
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          in_valid,
  input logic                                          out_valid,
  input logic signed [res_w(DATA_W,COEF_W,BIAS_W)-1:0] out_sum,
  input logic                                          lvl4_vld,
  input logic signed [prod_w(DATA_W,COEF_W)-1:0]       prod_last,
  input logic signed [prod_w(DATA_W,COEF_W)-1:0]       left_lane
);
  localparam longint BOUND = longint'(TAPS) * (longint'(1) << (DATA_W + COEF_W - 2))
                           + (longint'(1) << (BIAS_W - 1));

  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  // R5
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_sum == '0));

  // R3
  latency_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd7) |-> (out_valid == $past(in_valid, 7)));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd1 && !out_valid) |-> $stable(out_sum));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_sum) <= BOUND && longint'(out_sum) >= -BOUND));

  // R8
  bypass_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd5 && lvl4_vld) |-> (left_lane == $past(prod_last, 4)));
endmodule

bind window_dot25 window_dot25_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .BIAS_W(BIAS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid), .out_sum(out_sum),
  .lvl4_vld(lvl4_vld), .prod_last(prod_last), .left_lane(left_lane)
);

// File: tb/window_dot25_test.sv
`timescale 1ns/1ps
module window_dot25_test;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int BW = 16;
  localparam int RW = ((DW + CW + 5 > BW) ? DW + CW + 5 : BW) + 1;
  localparam int NL = 25;
  localparam int DEPTH = 7;
  localparam int DMIN = -(1 << (DW-1)), DMAX = (1 << (DW-1)) - 1;
  localparam int CMIN = -(1 << (CW-1)), CMAX = (1 << (CW-1)) - 1;
  localparam int BMIN = -(1 << (BW-1)), BMAX = (1 << (BW-1)) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  in_valid;
  logic [NL*DW-1:0]      win_flat;
  logic [NL*CW-1:0]      kern_flat;
  logic signed [BW-1:0]  bias;
  logic                  out_valid;
  logic signed [RW-1:0]  out_sum;

  always #2.5 clk = ~clk;

  window_dot25 #(.DATA_W(DW), .COEF_W(CW), .BIAS_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_flat(win_flat),
    .kern_flat(kern_flat), .bias(bias), .out_valid(out_valid), .out_sum(out_sum)
  );

  int     n_vec = 0, n_bad = 0;
  bit     done = 0;
  int     w [NL];
  int     k [NL];
  int     b;
  bit     ev_q [$];
  longint es_q [$];
  string  tg_q [$];
  longint last_val = 0;

  function automatic longint ref_dot();
    longint s = 0;
    for (int i = 0; i < NL; i++) s += longint'(w[i]) * longint'(k[i]);
    return s + longint'(b);
  endfunction

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic clear_ops();
    for (int i = 0; i < NL; i++) begin w[i] = 0; k[i] = 0; end
    b = 0;
  endtask

  task automatic fail(input string tg, input longint act, input longint exp);
    n_bad++;
    $display("FAIL %s: actual %0d expected %0d at %0t", tg, act, exp, $time);
  endtask

  // one clock: judge outputs, then drive the next input and queue its expectation
  task automatic step(input bit vld, input string tg);
    bit ev; longint es; string et;
    @(negedge clk);
    ev = ev_q.pop_front(); es = es_q.pop_front(); et = tg_q.pop_front();
    n_vec++;
    if (out_valid !== ev) fail("R3 out_valid", longint'(out_valid), longint'(ev));
    n_vec++;
    if (ev) begin
      if (longint'(out_sum) !== es) fail(et, longint'(out_sum), es);
      last_val = es;
    end else if (longint'(out_sum) !== last_val) begin
      fail("R6 hold", longint'(out_sum), last_val);
    end
    in_valid = vld;
    for (int i = 0; i < NL; i++) begin
      win_flat[i*DW +: DW]  = DW'(w[i]);
      kern_flat[i*CW +: CW] = CW'(k[i]);
    end
    bias = BW'(b);
    ev_q.push_back(vld);
    es_q.push_back(ref_dot());
    tg_q.push_back(tg);
  endtask

  task automatic random_ops();
    for (int i = 0; i < NL; i++) begin w[i] = rnd(DMIN, DMAX); k[i] = rnd(CMIN, CMAX); end
    b = rnd(BMIN, BMAX);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; win_flat = '0; kern_flat = '0; bias = '0;
    for (int i = 0; i < DEPTH; i++) begin ev_q.push_back(0); es_q.push_back(0); tg_q.push_back("R5"); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++; if (out_valid !== 1'b0) fail("R5 out_valid in reset", longint'(out_valid), 0);
    n_vec++; if (out_sum !== '0) fail("R5 out_sum in reset", longint'(out_sum), 0);
    rst_n = 1'b1;
    clear_ops();
    repeat (3) step(0, "R5");

    // R1: one lane at a time, distinct values
    for (int j = 0; j < NL; j++) begin
      clear_ops(); w[j] = j + 1; k[j] = -(j + 2); step(1, "R1");
    end

    // R8: bypass lane alone, interleaved with full-scale tree lanes
    for (int r = 0; r < 6; r++) begin
      clear_ops(); w[24] = DMIN; k[24] = (r % 2) ? CMAX : CMIN; b = r; step(1, "R8");
      clear_ops(); for (int i = 0; i < 24; i++) begin w[i] = DMAX; k[i] = CMAX; end step(1, "R8");
    end

    // R7: extremes
    clear_ops(); for (int i = 0; i < NL; i++) begin w[i] = DMIN; k[i] = CMIN; end b = BMAX; step(1, "R7");
    clear_ops(); for (int i = 0; i < NL; i++) begin w[i] = DMAX; k[i] = CMAX; end b = BMIN; step(1, "R7");
    clear_ops(); for (int i = 0; i < NL; i++) begin w[i] = DMIN; k[i] = CMAX; end b = BMIN; step(1, "R7");
    clear_ops(); for (int i = 0; i < NL; i++) begin w[i] = DMAX; k[i] = CMIN; end b = BMAX; step(1, "R7");
    clear_ops(); step(1, "R7");

    // R4: back-to-back random windows
    for (int r = 0; r < 300; r++) begin random_ops(); step(1, "R4"); end

    // R6: random gaps, garbage on inputs when invalid
    for (int r = 0; r < 300; r++) begin
      random_ops(); step(($urandom % 2) == 0, "R6");
    end

    // R2: operands drawn from extremes and zero
    for (int r = 0; r < 150; r++) begin
      for (int i = 0; i < NL; i++) begin
        case ($urandom % 4)
          0: w[i] = DMIN; 1: w[i] = DMAX; 2: w[i] = 0; default: w[i] = rnd(DMIN, DMAX);
        endcase
        case ($urandom % 4)
          0: k[i] = CMIN; 1: k[i] = CMAX; 2: k[i] = 0; default: k[i] = rnd(CMIN, CMAX);
        endcase
      end
      b = ($urandom % 2) ? BMIN : BMAX;
      step(1, "R2");
    end

    clear_ops();
    repeat (DEPTH + 3) step(0, "R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R3: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule